// File: doc/BRIEF.md
# Boot Source Selector and Block Loader

After reset this block takes the place of a processor's built-in start-up program. It watches four active-low mode pins and picks a boot source from them. When a parallel source is chosen, the block reads a boot image from external memory through a simple synchronous read port. It copies every code word of that image into on-chip RAM through a write port, then hands over the entry address together with a one-cycle start pulse. When the serial source is chosen, the block only raises a flag and does nothing else.

The image starts with two header words. The first gives the memory width and the second is a configuration word. The block presents the configuration word on an output register. After the header come blocks. Each block holds a word count, a destination address and then the data words. A zero count ends the image. In 8-bit and 16-bit memories each word is built from consecutive narrow reads, least significant part first.

Top module: `boot_loader_top`

## Requirements
- R1: Mode pins `mode_n[3:0]` are active low, with bit k standing for pin k. They are checked in the priority order bit 3, bit 0, bit 1, bit 2, and the first asserted pin wins. The pins are sampled only while the block is polling, so later pin changes have no effect until the next reset.
- R2: While no pin is asserted the block keeps polling. It issues no memory read and no start pulse.
- R3: Bit 0 selects source base 0x001000, bit 1 selects 0x400000 and bit 2 selects 0xFFF000. The first memory read goes to the chosen base.
- R4: Bit 3 selects serial boot. `serial_boot` goes high and stays high, and no memory read, RAM write or start pulse follows.
- R5: The first header word is fetched with a single full 32-bit read. The value 8 selects byte mode, 16 selects half-word mode, and any other value selects 32-bit mode.
- R6: The second header word appears on `cfg_word` and is held there.
- R7: In byte mode the data is taken from `mem_rdata[7:0]`, and four reads form one word, first read in bits 7:0. In half-word mode the data is taken from `mem_rdata[15:0]`, and two reads form one word, first read in bits 15:0.
- R8: Each read goes to the address one above the previous read.
- R9: For each block the data words are written to RAM at consecutive addresses starting at the block's destination, in image order.
- R10: A block count of zero ends loading. `start` then pulses high for exactly one cycle, and `entry_addr` holds the destination of the first block, or 0 if the image has no blocks.
- R11: A read is a one-cycle `mem_rd` pulse, and its data is expected on `mem_rdata` in the following cycle. Only one read is in flight at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_n | input | 4 | Active-low boot mode pins (asynchronous) |
| mem_rd | output | 1 | External read strobe |
| mem_addr | output | AW | External read address |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | AW | RAM write address |
| ram_wdata | output | 32 | RAM write data |
| cfg_word | output | 32 | Captured configuration header word |
| entry_addr | output | AW | Address where execution begins |
| start | output | 1 | One-cycle pulse when loading is complete |
| serial_boot | output | 1 | Serial boot was selected |

## Verification
The bench asserts several pins at once to test the priority order. A wrong order shows up as the wrong first read address, or as a serial flag where a load was expected. It also changes the pins in the middle of a load; a design that does not latch its choice would abandon the load or raise the serial flag. Images in byte and half-word width catch reversed part order and wrong address stepping, because these corrupt every word the scoreboard compares. An image with no blocks, and a width word that is neither 8 nor 16, check the entry address default and the width fallback.

// File: rtl/boot_pkg.sv
package boot_pkg;
  localparam int WORD_W = 32;
  typedef enum logic [1:0] {WID_8, WID_16, WID_32} wid_e;
endpackage

// File: rtl/boot_mode_sel.sv
module boot_mode_sel #(
  parameter int AW = 24,
  parameter logic [AW-1:0] BASE0 = 24'h001000,
  parameter logic [AW-1:0] BASE1 = 24'h400000,
  parameter logic [AW-1:0] BASE2 = 24'hFFF000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    mode_n,
  output logic          hit,
  output logic          is_serial,
  output logic [AW-1:0] base
);
  logic [3:0] sync1, sync2, act;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 4'hF;
      sync2 <= 4'hF;
    end else begin
      sync1 <= mode_n;
      sync2 <= sync1;
    end
  end

  assign act = ~sync2;

  // priority: pin 3 (serial), then 0, 1, 2
  always_comb begin
    hit       = 1'b1;
    is_serial = 1'b0;
    base      = '0;
    if (act[3])      is_serial = 1'b1;
    else if (act[0]) base = BASE0;
    else if (act[1]) base = BASE1;
    else if (act[2]) base = BASE2;
    else             hit = 1'b0;
  end
endmodule

// File: rtl/boot_fetch.sv
module boot_fetch
  import boot_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [AW-1:0]     load_addr,
  input  logic              go,
  input  wid_e              wid,
  output logic              mem_rd,
  output logic [AW-1:0]     mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              word_vld,
  output logic [WORD_W-1:0] word
);
  typedef enum logic [1:0] {F_IDLE, F_RD, F_WAIT} fst_e;
  fst_e              fst;
  logic [1:0]        part;
  logic [1:0]        last_part;
  logic [WORD_W-1:0] acc, acc_next;
  logic              rd_q;
  logic [AW-1:0]     addr_q;

  always_comb begin
    case (wid)
      WID_8:   begin last_part = 2'd3; acc_next = {mem_rdata[7:0], acc[WORD_W-1:8]}; end
      WID_16:  begin last_part = 2'd1; acc_next = {mem_rdata[15:0], acc[WORD_W-1:16]}; end
      default: begin last_part = 2'd0; acc_next = mem_rdata; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fst      <= F_IDLE;
      part     <= '0;
      acc      <= '0;
      rd_q     <= 1'b0;
      addr_q   <= '0;
      word_vld <= 1'b0;
      word     <= '0;
    end else begin
      word_vld <= 1'b0;
      if (load) addr_q <= load_addr;
      case (fst)
        F_IDLE: if (go && !word_vld) begin
          fst  <= F_RD;
          rd_q <= 1'b1;
          part <= '0;
        end
        F_RD: begin
          rd_q <= 1'b0;
          fst  <= F_WAIT;
        end
        F_WAIT: begin
          addr_q <= addr_q + AW'(1);
          acc    <= acc_next;
          if (part == last_part) begin
            word_vld <= 1'b1;
            word     <= acc_next;
            fst      <= F_IDLE;
          end else begin
            part <= part + 2'd1;
            rd_q <= 1'b1;
            fst  <= F_RD;
          end
        end
        default: fst <= F_IDLE;
      endcase
    end
  end

  assign mem_rd   = rd_q;
  assign mem_addr = addr_q;

  AST_ONE_READ: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd); // R11
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (fst == F_WAIT) |=> (mem_addr == $past(mem_addr) + AW'(1))); // R8
endmodule

// File: rtl/boot_seq.sv
module boot_seq
  import boot_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic              is_serial,
  input  logic [AW-1:0]     base,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word,
  output logic              load,
  output logic [AW-1:0]     load_addr,
  output logic              go,
  output wid_e              wid,
  output logic              ram_we,
  output logic [AW-1:0]     ram_addr,
  output logic [WORD_W-1:0] ram_wdata,
  output logic [WORD_W-1:0] cfg_word,
  output logic [AW-1:0]     entry_addr,
  output logic              start,
  output logic              serial_boot
);
  typedef enum logic [3:0] {
    S_POLL, S_WIDTH, S_CFG, S_LEN, S_DST, S_DATA, S_GO, S_DONE, S_SER
  } sst_e;

  sst_e              st;
  logic [WORD_W-1:0] len_q;
  logic [AW-1:0]     waddr_q;
  logic              first_q;

  always_comb begin
    go        = (st == S_WIDTH) || (st == S_CFG) || (st == S_LEN) ||
                (st == S_DST) || (st == S_DATA);
    load      = (st == S_POLL) && hit && !is_serial;
    load_addr = base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_POLL;
      wid         <= WID_32;
      len_q       <= '0;
      waddr_q     <= '0;
      first_q     <= 1'b1;
      ram_we      <= 1'b0;
      ram_addr    <= '0;
      ram_wdata   <= '0;
      cfg_word    <= '0;
      entry_addr  <= '0;
      start       <= 1'b0;
      serial_boot <= 1'b0;
    end else begin
      ram_we <= 1'b0;
      start  <= 1'b0;
      case (st)
        S_POLL: begin
          wid     <= WID_32;
          first_q <= 1'b1;
          if (hit) begin
            if (is_serial) begin
              serial_boot <= 1'b1;
              st          <= S_SER;
            end else begin
              st <= S_WIDTH;
            end
          end
        end
        S_WIDTH: if (word_vld) begin
          if (word == 32'd8)       wid <= WID_8;
          else if (word == 32'd16) wid <= WID_16;
          else                     wid <= WID_32;
          st <= S_CFG;
        end
        S_CFG: if (word_vld) begin
          cfg_word <= word;
          st       <= S_LEN;
        end
        S_LEN: if (word_vld) begin
          if (word == '0) begin
            st <= S_GO;
          end else begin
            len_q <= word;
            st    <= S_DST;
          end
        end
        S_DST: if (word_vld) begin
          waddr_q <= word[AW-1:0];
          if (first_q) begin
            entry_addr <= word[AW-1:0];
            first_q    <= 1'b0;
          end
          st <= S_DATA;
        end
        S_DATA: if (word_vld) begin
          ram_we    <= 1'b1;
          ram_addr  <= waddr_q;
          ram_wdata <= word;
          waddr_q   <= waddr_q + AW'(1);
          len_q     <= len_q - 32'd1;
          if (len_q == 32'd1) st <= S_LEN;
        end
        S_GO: begin
          start <= 1'b1;
          st    <= S_DONE;
        end
        default: ;
      endcase
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    start |=> !start); // R10
  AST_SERIAL_HOLD: assert property (@(posedge clk) disable iff (rst)
    serial_boot |=> serial_boot); // R4
  AST_SERIAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    serial_boot |-> (!start && !ram_we && !go)); // R4
endmodule

// File: rtl/boot_loader_top.sv
module boot_loader_top
  import boot_pkg::*;
#(
  parameter int AW = 24,
  parameter logic [AW-1:0] BASE0 = 24'h001000,
  parameter logic [AW-1:0] BASE1 = 24'h400000,
  parameter logic [AW-1:0] BASE2 = 24'hFFF000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        mode_n,
  output logic              mem_rd,
  output logic [AW-1:0]     mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              ram_we,
  output logic [AW-1:0]     ram_addr,
  output logic [WORD_W-1:0] ram_wdata,
  output logic [WORD_W-1:0] cfg_word,
  output logic [AW-1:0]     entry_addr,
  output logic              start,
  output logic              serial_boot
);
  logic              hit, is_serial, load, go, word_vld;
  logic [AW-1:0]     base, load_addr;
  logic [WORD_W-1:0] word;
  wid_e              wid;

  boot_mode_sel #(.AW(AW), .BASE0(BASE0), .BASE1(BASE1), .BASE2(BASE2)) u_sel (
    .clk(clk), .rst(rst), .mode_n(mode_n),
    .hit(hit), .is_serial(is_serial), .base(base)
  );

  boot_fetch #(.AW(AW)) u_fetch (
    .clk(clk), .rst(rst), .load(load), .load_addr(load_addr), .go(go),
    .wid(wid), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .word_vld(word_vld), .word(word)
  );

  boot_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst(rst), .hit(hit), .is_serial(is_serial), .base(base),
    .word_vld(word_vld), .word(word), .load(load), .load_addr(load_addr),
    .go(go), .wid(wid), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .cfg_word(cfg_word), .entry_addr(entry_addr),
    .start(start), .serial_boot(serial_boot)
  );
endmodule

// File: tb/tb_boot_loader_top.sv
`timescale 1ns/1ps
module tb_boot_loader_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  mode_n = 4'hF;
  logic        mem_rd, ram_we, start, serial_boot;
  logic [23:0] mem_addr, ram_addr, entry_addr;
  logic [31:0] mem_rdata = '0, ram_wdata, cfg_word;

  always #2 clk = ~clk;

  boot_loader_top dut (
    .clk(clk), .rst(rst), .mode_n(mode_n), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .cfg_word(cfg_word), .entry_addr(entry_addr),
    .start(start), .serial_boot(serial_boot)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] mem [int];
  int ptr, cur_w;
  logic [55:0] expq[$];
  int rd_cnt, wr_cnt, start_cnt;
  logic [23:0] first_addr, last_addr;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // memory model: one cycle read latency
  always @(posedge clk)
    if (mem_rd) mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 32'h0;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_rd) begin
        rd_cnt++;
        if (rd_cnt == 1) first_addr = mem_addr;
        else chk(mem_addr == last_addr + 24'd1, "R8", {8'h0, mem_addr}, {8'h0, last_addr + 24'd1});
        last_addr = mem_addr;
      end
      if (ram_we) begin
        wr_cnt++;
        if (expq.size() == 0) chk(0, "R9 unexpected write", {8'h0, ram_addr}, 32'h0);
        else begin
          logic [55:0] e;
          e = expq.pop_front();
          chk(ram_addr == e[55:32], "R9 addr", {8'h0, ram_addr}, {8'h0, e[55:32]});
          chk(ram_wdata == e[31:0], "R7/R9 data", ram_wdata, e[31:0]);
        end
      end
      if (start) start_cnt++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    finish_run();
  end

  // image driver
  task automatic img_begin(input int base, input int wbits, input logic [31:0] cfg);
    mem.delete();
    expq.delete();
    mem[base] = wbits;
    ptr = base + 1;
    cur_w = (wbits == 8) ? 8 : (wbits == 16) ? 16 : 32;
    img_word(cfg);
  endtask

  task automatic img_word(input logic [31:0] v);
    if (cur_w == 8) begin
      for (int i = 0; i < 4; i++) begin mem[ptr] = {24'h0, v[8*i +: 8]}; ptr++; end
    end else if (cur_w == 16) begin
      for (int i = 0; i < 2; i++) begin mem[ptr] = {16'h0, v[16*i +: 16]}; ptr++; end
    end else begin
      mem[ptr] = v; ptr++;
    end
  endtask

  task automatic img_block(input logic [23:0] dst, input int len, input logic [31:0] seed);
    img_word(len);
    img_word({8'h0, dst});
    for (int i = 0; i < len; i++) begin
      logic [31:0] d;
      d = seed ^ (32'h01030507 * (i + 1));
      img_word(d);
      expq.push_back({dst + 24'(i), d});
    end
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst = 1'b1;
    mode_n = 4'hF;
    repeat (3) @(negedge clk);
    rd_cnt = 0; wr_cnt = 0; start_cnt = 0;
    rst = 1'b0;
  endtask

  task automatic wait_start(input string req);
    int n = 0;
    while (start_cnt == 0 && n < 5000) begin @(negedge clk); n++; end
    chk(start_cnt != 0, req, 32'(start_cnt), 32'h1);
    repeat (10) @(negedge clk);
    chk(start_cnt == 1, "R10 single pulse", 32'(start_cnt), 32'h1);
    chk(expq.size() == 0, "R9 all words written", 32'(expq.size()), 32'h0);
  endtask

  initial begin
    // reset state
    reset_dut();
    @(negedge clk);
    chk({mem_rd, ram_we, start, serial_boot} == 4'b0, "R2 reset outputs", {28'h0, mem_rd, ram_we, start, serial_boot}, 32'h0);
    chk(cfg_word == 0 && entry_addr == 0, "R6/R10 reset regs", cfg_word, 32'h0);

    // no pin asserted
    repeat (60) @(negedge clk);
    chk(rd_cnt == 0 && start_cnt == 0, "R2 idle polling", 32'(rd_cnt), 32'h0);

    // pin 0, 32-bit, two blocks, pins change mid-load
    reset_dut();
    img_begin(32'h001000, 32, 32'hC0DE1234);
    img_block(24'h000100, 3, 32'hA5A50000);
    img_block(24'h000200, 2, 32'h5A5A1111);
    img_word(0);
    mode_n = 4'b1110;
    repeat (30) @(negedge clk);
    mode_n = 4'b0111;
    wait_start("R10 start pin0");
    chk(first_addr == 24'h001000, "R3 base pin0", {8'h0, first_addr}, 32'h001000);
    chk(cfg_word == 32'hC0DE1234, "R6 cfg", cfg_word, 32'hC0DE1234);
    chk(entry_addr == 24'h000100, "R10 entry", {8'h0, entry_addr}, 32'h100);
    chk(serial_boot == 0, "R1 pins ignored after choice", {31'h0, serial_boot}, 32'h0);
    chk(wr_cnt == 5, "R9 write count", 32'(wr_cnt), 32'd5);

    // pins 1 and 2 asserted: pin 1 wins, byte mode
    reset_dut();
    img_begin(32'h400000, 8, 32'h00112233);
    img_block(24'h003000, 2, 32'h12345678);
    img_block(24'h003100, 1, 32'h89ABCDEF);
    img_word(0);
    mode_n = 4'b1001;
    wait_start("R10 start pin1");
    chk(first_addr == 24'h400000, "R1/R3 base pin1", {8'h0, first_addr}, 32'h400000);
    chk(cfg_word == 32'h00112233, "R6/R7 cfg byte mode", cfg_word, 32'h00112233);
    chk(entry_addr == 24'h003000, "R10 entry byte mode", {8'h0, entry_addr}, 32'h3000);
    chk(rd_cnt == 1 + 4 * (1 + 2 + 2 + 2 + 1 + 1), "R5/R7 byte read count", 32'(rd_cnt), 32'd37);

    // pin 2, half-word mode
    reset_dut();
    img_begin(32'hFFF000, 16, 32'hFEEDBEEF);
    img_block(24'h0ABCDE, 3, 32'h0F0F0F0F);
    img_word(0);
    mode_n = 4'b1011;
    wait_start("R10 start pin2");
    chk(first_addr == 24'hFFF000, "R3 base pin2", {8'h0, first_addr}, 32'hFFF000);
    chk(cfg_word == 32'hFEEDBEEF, "R6/R7 cfg half mode", cfg_word, 32'hFEEDBEEF);
    chk(rd_cnt == 1 + 2 * (1 + 2 + 3 + 1), "R5/R7 half read count", 32'(rd_cnt), 32'd15);

    // odd width value falls back to 32-bit
    reset_dut();
    img_begin(32'h001000, 5, 32'h0000CAFE);
    img_block(24'h000055, 1, 32'h77777777);
    img_word(0);
    mode_n = 4'b1110;
    wait_start("R10 start width fallback");
    chk(rd_cnt == 6, "R5 32-bit fallback", 32'(rd_cnt), 32'd6);

    // terminator only
    reset_dut();
    img_begin(32'h001000, 32, 32'h00000042);
    img_word(0);
    mode_n = 4'b1110;
    wait_start("R10 start empty image");
    chk(entry_addr == 24'h0, "R10 entry default", {8'h0, entry_addr}, 32'h0);
    chk(wr_cnt == 0, "R10 no writes", 32'(wr_cnt), 32'h0);

    // serial over pin 0
    reset_dut();
    mode_n = 4'b0110;
    repeat (80) @(negedge clk);
    chk(serial_boot == 1, "R4 serial flag", {31'h0, serial_boot}, 32'h1);
    chk(rd_cnt == 0 && start_cnt == 0 && wr_cnt == 0, "R1/R4 serial quiet", 32'(rd_cnt + start_cnt + wr_cnt), 32'h0);

    finish_run();
  end
endmodule